// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This block builds the second operand of an ALU data-processing operation. It takes a 32-bit value and applies one of four shift kinds to it: logical left, logical right, arithmetic right or rotate right. It returns the shifted word together with the shifter carry-out that the flag logic may capture. The block has no clock or state, and its outputs follow its inputs in the same cycle.

A mode input chooses where the shift count comes from. In immediate mode only the low five bits of the amount input count, and a count of zero does not mean "no shift" for every kind: it stands for a full 32-bit right shift or for a one-bit rotate through the carry. In register mode the full 8-bit count applies. Counts of 32 or more saturate, each kind in its own way, and the carry-out is defined for every count.

Internally, a decoder sorts each request into one operation class: pass, partial, whole, beyond, extend or wrap. The datapath and the carry selector then act on that class.

Top module: `sop_shifter_unit`

## Requirements
- R1: `kind_i` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. With `use_reg_i` = 0 (immediate mode) only `amount_i[4:0]` is used and bits 7..5 have no effect on either output.
- R2: Immediate mode, logical left with count 0: `result_o` equals `opnd_i` and `carry_o` equals `carry_i`.
- R3: Immediate mode, logical right with count 0 acts as a shift by 32: `result_o` is 0 and `carry_o` is `opnd_i[31]`.
- R4: Arithmetic right shift, with an immediate count of 0 or a register count of 32 or more: every bit of `result_o` equals `opnd_i[31]`, and so does `carry_o`.
- R5: Immediate mode, rotate right with count 0 rotates through the carry: `result_o` = {`carry_i`, `opnd_i[31:1]`} and `carry_o` = `opnd_i[0]`.
- R6: Register mode with `amount_i` = 0 leaves the value unchanged for all four kinds, and `carry_o` equals `carry_i`.
- R7: Register mode, logical left or logical right with a count of 32 or more gives `result_o` = 0. At exactly 32, `carry_o` is `opnd_i[0]` for left and `opnd_i[31]` for right. Above 32, `carry_o` is 0.
- R8: Register mode rotate uses only `amount_i[4:0]`. If those bits are 0 while `amount_i` is not 0, `result_o` equals `opnd_i` and `carry_o` equals `opnd_i[31]`.
- R9: For an effective count n in 1..31:
  - Logical left gives `opnd_i` << n with carry `opnd_i[32-n]`.
  - Logical right and arithmetic right give the logical or sign-filling shift, with carry `opnd_i[n-1]`.
  - Rotate right gives the rotated word with carry `opnd_i[n-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Value to be shifted |
| kind_i | input | 2 | Shift kind (encoding in R1) |
| amount_i | input | 8 | Shift count: low 5 bits in immediate mode, all 8 in register mode |
| use_reg_i | input | 1 | 0 = immediate count, 1 = register count |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bound checker re-evaluates its checks whenever the inputs change. It covers the zero-count cases of both modes, the sign fill of arithmetic shifts, the rotate through carry, the saturation of logical shifts above 32, and bit-count conservation for rotates. Three things can only be shown by the bench, which compares both outputs against its own wide-arithmetic reference model:
- the exact carry bit chosen for in-range counts;
- the exact-32 boundary;
- the fact that the upper count bits are ignored in immediate mode.

The bench sweeps the corner counts 0, 1, 31, 32, 33 and 255, plus rotate multiples of 32, for every kind and mode, then adds seeded random requests.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int DATA_W = 32;
    localparam int AMT_W  = 8;
    localparam int LOG_W  = $clog2(DATA_W);

    // Shift kind encoding; the values are fixed by the instruction field.
    typedef enum logic [1:0] {
        KIND_LSL = 2'd0,
        KIND_LSR = 2'd1,
        KIND_ASR = 2'd2,
        KIND_ROR = 2'd3
    } shift_kind_e;

    // Operation class chosen by the count decoder.
    typedef enum logic [2:0] {
        OP_PASS   = 3'd0,  // value through, carry flag through
        OP_PART   = 3'd1,  // ordinary shift by 1..W-1
        OP_WHOLE  = 3'd2,  // shift by exactly W
        OP_BEYOND = 3'd3,  // shift by more than W
        OP_EXTEND = 3'd4,  // one-bit rotate through carry
        OP_WRAP   = 3'd5   // rotate by a nonzero multiple of W
    } op_class_e;

endpackage

// File: rtl/sop_amount_decode.sv
module sop_amount_decode
    import sop_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = AMT_W
) (
    input  shift_kind_e                kind_i,
    input  logic [AW-1:0]              amount_i,
    input  logic                       use_reg_i,
    output op_class_e                  op_o,
    output logic [$clog2(DW)-1:0]      n_o
);
    localparam int LW = $clog2(DW);
    localparam logic [AW-1:0] FULL_AMT = AW'(DW);

    logic [LW-1:0] low_bits;
    assign low_bits = amount_i[LW-1:0];
    assign n_o      = low_bits;

    always_comb begin
        op_o = OP_PART;
        if (!use_reg_i) begin
            if (low_bits == '0) begin
                unique case (kind_i)
                    KIND_LSL: op_o = OP_PASS;
                    KIND_LSR: op_o = OP_WHOLE;
                    KIND_ASR: op_o = OP_WHOLE;
                    KIND_ROR: op_o = OP_EXTEND;
                    default:  op_o = OP_PASS;
                endcase
            end
        end else if (amount_i == '0) begin
            op_o = OP_PASS;
        end else if (kind_i == KIND_ROR) begin
            op_o = (low_bits == '0) ? OP_WRAP : OP_PART;
        end else if (amount_i == FULL_AMT) begin
            op_o = OP_WHOLE;
        end else if (amount_i > FULL_AMT) begin
            op_o = OP_BEYOND;
        end
    end
endmodule

// File: rtl/sop_datapath.sv
module sop_datapath
    import sop_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0]              opnd_i,
    input  shift_kind_e                kind_i,
    input  op_class_e                  op_i,
    input  logic [$clog2(DW)-1:0]      n_i,
    input  logic                       carry_i,
    output logic [DW-1:0]              result_o
);
    logic [DW-1:0] part_res;
    logic [DW-1:0] sat_res;
    logic [DW-1:0] rot_stage [$clog2(DW)+1];

    // Rotate-right barrel: one stage per count bit.
    assign rot_stage[0] = opnd_i;
    for (genvar s = 0; s < $clog2(DW); s++) begin : g_rot
        assign rot_stage[s+1] = n_i[s]
            ? {rot_stage[s][(2**s)-1:0], rot_stage[s][DW-1:2**s]}
            : rot_stage[s];
    end

    always_comb begin
        unique case (kind_i)
            KIND_LSL: part_res = opnd_i << n_i;
            KIND_LSR: part_res = opnd_i >> n_i;
            KIND_ASR: part_res = DW'($signed(opnd_i) >>> n_i);
            KIND_ROR: part_res = rot_stage[$clog2(DW)];
            default:  part_res = opnd_i;
        endcase
        sat_res = (kind_i == KIND_ASR) ? {DW{opnd_i[DW-1]}} : '0;
    end

    always_comb begin
        unique case (op_i)
            OP_PASS:   result_o = opnd_i;
            OP_PART:   result_o = part_res;
            OP_WHOLE:  result_o = sat_res;
            OP_BEYOND: result_o = sat_res;
            OP_EXTEND: result_o = {carry_i, opnd_i[DW-1:1]};
            OP_WRAP:   result_o = opnd_i;
            default:   result_o = opnd_i;
        endcase
    end
endmodule

// File: rtl/sop_carry_pick.sv
module sop_carry_pick
    import sop_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0]              opnd_i,
    input  shift_kind_e                kind_i,
    input  op_class_e                  op_i,
    input  logic [$clog2(DW)-1:0]      n_i,
    input  logic                       carry_i,
    output logic                       carry_o
);
    logic [DW:0] ext_left;
    logic [DW:0] ext_right;
    logic        part_c;
    logic        msb;

    assign msb       = opnd_i[DW-1];
    assign ext_left  = {1'b0, opnd_i} << n_i;   // bit DW holds opnd[DW-n]
    assign ext_right = {opnd_i, 1'b0} >> n_i;   // bit 0 holds opnd[n-1]
    assign part_c    = (kind_i == KIND_LSL) ? ext_left[DW] : ext_right[0];

    always_comb begin
        unique case (op_i)
            OP_PASS:   carry_o = carry_i;
            OP_PART:   carry_o = part_c;
            OP_WHOLE:  carry_o = (kind_i == KIND_LSL) ? opnd_i[0] : msb;
            OP_BEYOND: carry_o = (kind_i == KIND_ASR) ? msb : 1'b0;
            OP_EXTEND: carry_o = opnd_i[0];
            OP_WRAP:   carry_o = msb;
            default:   carry_o = carry_i;
        endcase
    end
endmodule

// File: rtl/sop_shifter_unit.sv
module sop_shifter_unit
    import sop_pkg::*;
(
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [1:0]        kind_i,
    input  logic [AMT_W-1:0]  amount_i,
    input  logic              use_reg_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    shift_kind_e      kind;
    op_class_e        op;
    logic [LOG_W-1:0] n;

    assign kind = shift_kind_e'(kind_i);

    sop_amount_decode #(.DW(DATA_W), .AW(AMT_W)) u_dec (
        .kind_i    (kind),
        .amount_i  (amount_i),
        .use_reg_i (use_reg_i),
        .op_o      (op),
        .n_o       (n)
    );

    sop_datapath #(.DW(DATA_W)) u_dp (
        .opnd_i   (opnd_i),
        .kind_i   (kind),
        .op_i     (op),
        .n_i      (n),
        .carry_i  (carry_i),
        .result_o (result_o)
    );

    sop_carry_pick #(.DW(DATA_W)) u_cp (
        .opnd_i  (opnd_i),
        .kind_i  (kind),
        .op_i    (op),
        .n_i     (n),
        .carry_i (carry_i),
        .carry_o (carry_o)
    );
endmodule

// File: rtl/sop_shifter_unit_chk.sv
module sop_shifter_unit_chk
    import sop_pkg::*;
(
    input logic [DATA_W-1:0] opnd_i,
    input logic [1:0]        kind_i,
    input logic [AMT_W-1:0]  amount_i,
    input logic              use_reg_i,
    input logic              carry_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o
);
    logic imm_zero;
    assign imm_zero = (amount_i[LOG_W-1:0] == '0);

    always_comb begin
        if (use_reg_i && amount_i == '0)
            AST_REG_ZERO_PASS: assert (result_o == opnd_i && carry_o == carry_i); // R6
        if (!use_reg_i && kind_i == 2'd0 && imm_zero)
            AST_IMM_LSL_ZERO: assert (result_o == opnd_i && carry_o == carry_i); // R2
        if (!use_reg_i && kind_i == 2'd1 && imm_zero)
            AST_IMM_LSR_FULL: assert (result_o == '0 && carry_o == opnd_i[DATA_W-1]); // R3
        if (kind_i == 2'd2 && (use_reg_i ? amount_i >= AMT_W'(DATA_W) : imm_zero))
            AST_ASR_SIGN_FILL: assert ((result_o == '0 || result_o == '1) && result_o[0] == opnd_i[DATA_W-1] && carry_o == opnd_i[DATA_W-1]); // R4
        if (!use_reg_i && kind_i == 2'd3 && imm_zero)
            AST_RRX_THROUGH_CARRY: assert (result_o[DATA_W-1] == carry_i && carry_o == opnd_i[0] && result_o[DATA_W-2:0] == opnd_i[DATA_W-1:1]); // R5
        if (use_reg_i && kind_i[1] == 1'b0 && amount_i > AMT_W'(DATA_W))
            AST_LOGIC_BEYOND_ZERO: assert (result_o == '0 && carry_o == 1'b0); // R7
        if (kind_i == 2'd3 && !(!use_reg_i && imm_zero))
            AST_ROR_KEEPS_ONES: assert ($countones(result_o) == $countones(opnd_i)); // R8
    end
endmodule

bind sop_shifter_unit sop_shifter_unit_chk u_chk (.*);

// File: tb/sop_shifter_unit_tb_top.sv
module sop_shifter_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic [31:0] opnd;
    logic [1:0]  kind;
    logic [7:0]  amount;
    logic        use_reg;
    logic        cin;
    logic [31:0] result;
    logic        cout;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sop_shifter_unit dut_i (
        .opnd_i(opnd), .kind_i(kind), .amount_i(amount),
        .use_reg_i(use_reg), .carry_i(cin),
        .result_o(result), .carry_o(cout)
    );

    // Reference: {carry, result} from wide arithmetic.
    function automatic logic [32:0] model(logic [31:0] v, logic [1:0] k,
                                          logic [7:0] a, logic r, logic c);
        int n;
        logic [63:0] w;
        logic signed [63:0] sw;
        logic [63:0] dbl;
        if (!r) begin
            n = int'(a[4:0]);
            if (n == 0) begin
                case (k)
                    2'd0: return {c, v};
                    2'd1: return {v[31], 32'd0};
                    2'd2: return {v[31], {32{v[31]}}};
                    default: return {v[0], c, v[31:1]};
                endcase
            end
        end else begin
            n = int'(a);
            if (n == 0) return {c, v};
            if (k == 2'd3) begin
                n = n % 32;
                if (n == 0) return {v[31], v};
            end
        end
        case (k)
            2'd0: begin w = {32'd0, v} << n; return {w[32], w[31:0]}; end
            2'd1: begin w = {v, 32'd0} >> n; return {w[31], w[63:32]}; end
            2'd2: begin sw = $signed({v, 32'd0}) >>> n; return {sw[31], sw[63:32]}; end
            default: begin dbl = {v, v} >> n; return {v[n-1], dbl[31:0]}; end
        endcase
    endfunction

    function automatic string tag(logic [1:0] k, logic [7:0] a, logic r);
        if (!r && a[7:5] != 3'd0) return "R1";
        if (!r && a[4:0] == 5'd0)
            return (k == 2'd0) ? "R2" : (k == 2'd1) ? "R3" : (k == 2'd2) ? "R4" : "R5";
        if (r && a == 8'd0) return "R6";
        if (r && k == 2'd3 && a[4:0] == 5'd0) return "R8";
        if (r && k == 2'd2 && a >= 8'd32) return "R4";
        if (r && a >= 8'd32 && k != 2'd3) return "R7";
        return "R9";
    endfunction

    task automatic apply(logic [31:0] v, logic [1:0] k, logic [7:0] a, logic r, logic c);
        logic [32:0] exp_v;
        opnd = v; kind = k; amount = a; use_reg = r; cin = c;
        #1;
        exp_v = model(v, k, a, r, c);
        n_tests++;
        if (result !== exp_v[31:0] || cout !== exp_v[32]) begin
            n_fail++;
            $display("FAIL %s kind=%0d amt=%0d reg=%0d cin=%0d opnd=%h: got %h/%b exp %h/%b",
                     tag(k, a, r), k, a, r, c, v, result, cout, exp_v[31:0], exp_v[32]);
        end
        #(CLK_PERIOD - 1);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        logic [7:0]  corners [10];
        int unused_seed;
        pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hA5C3_0F96; pats[3] = 32'h0000_0000;
        corners[0] = 8'd0;  corners[1] = 8'd1;  corners[2] = 8'd31;
        corners[3] = 8'd32; corners[4] = 8'd33; corners[5] = 8'd255;
        corners[6] = 8'd64; corners[7] = 8'd96; corners[8] = 8'd224;
        corners[9] = 8'd37;
        unused_seed = $urandom(32'd20240611);
        // Reset-like state: all inputs zero gives zero result and carry.
        apply(32'd0, 2'd0, 8'd0, 1'b0, 1'b0); // R2
        // Directed corners, every kind, mode, pattern and carry.
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 4; k++)
                for (int ci = 0; ci < 10; ci++)
                    for (int m = 0; m < 2; m++)
                        for (int c = 0; c < 2; c++)
                            apply(pats[p], 2'(k), corners[ci], 1'(m), 1'(c));
        // R1: upper count bits in immediate mode change nothing.
        for (int k = 0; k < 4; k++) begin
            apply(32'hDEAD_BEEF, 2'(k), 8'hE0, 1'b0, 1'b1); // R1
            apply(32'hDEAD_BEEF, 2'(k), 8'hA5, 1'b0, 1'b0); // R1
        end
        // Seeded random requests.
        for (int i = 0; i < 3000; i++)
            apply($urandom, 2'($urandom), 8'($urandom), 1'($urandom), 1'($urandom)); // R9
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule